// File: doc/BRIEF.md
# Indirect Fuse Byte Reader over a Narrow Register Bus

This block copies a run of fuse bytes out of a fuse macro that can only be reached through a small 8-bit register bus. It is given a start pulse, a first fuse address and a byte count. For each address it then drives a fixed program on that bus. Four masked writes arm the macro, load the address and launch the read. The block then polls a control register until the macro reports ready, and reads the byte from a separate result register. Each byte leaves as a one-cycle strobe, in ascending address order.

The bus carries one transaction at a time, using a request/acknowledge handshake. The slave merges a masked write into its register itself. Every acknowledge carries an error flag. An error on a write or on a data read ends the dump at once. A failed poll is treated as "not yet ready" and is retried after a fixed pause. A limit on the number of polls also ends the dump. In either case the dump ends with a completion pulse and an error flag.

Top module: `fuse_si_reader`

## Requirements
- R1: After reset the block is idle: `busy_o`, `bus_req_o`, `byte_valid_o`, `done_o` and `error_o` are all low.
- R2: For each fuse address A the block issues four writes, in this order. First, 0x40 to the control register (0x60) with mask 0xFF. Second, A[7:0] to the low-address register (0x61) with mask 0xFF. Third, A>>8 to the control register with mask 0x0F. Fourth, 0x00 to the control register with mask 0xC0.
- R3: After the writes, the block reads the control register (0x60). The poll succeeds only if the acknowledge reports no error and bit 5 of the read data is set. A failed poll is followed by exactly POLL_GAP cycles with `bus_req_o` low, and then another poll.
- R4: If POLL_LIMIT polls for one address all fail, no further request is made. The next cycle shows `done_o` and `error_o` high.
- R5: After a successful poll, the block reads the result register (0x62). The cycle after that read is acknowledged without error, `byte_valid_o` pulses with the read data on `byte_o`. Bytes leave for addresses base, base+1, …, up to `len_i` of them.
- R6: While `bus_req_o` is high and not acknowledged, the request and all its fields hold steady. A transaction completes in a cycle with both `bus_req_o` and `bus_ack_i` high, and only one is outstanding.
- R7: An acknowledged error on any write or on a result-register read stops the dump. The next cycle shows `done_o` and `error_o` high, no byte is delivered for that address, and no further request follows.
- R8: A dump that succeeds raises `done_o` with `error_o` low in the same cycle as the last `byte_valid_o`. The block is idle in that cycle.
- R9: A start with `len_i` = 0 causes no bus traffic. `done_o` pulses, with `error_o` low, in the cycle after the start.
- R10: `start_i` is ignored while `busy_o` is high. The running dump keeps its base address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a dump (taken only when idle) |
| base_i | input | ADDR_W | First fuse address |
| len_i | input | LEN_W | Number of bytes to read |
| bus_req_o | output | 1 | Register bus request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_wmask_o | output | 8 | Bits of the register that the write may change |
| bus_ack_i | input | 1 | Transaction complete |
| bus_err_i | input | 1 | Completed transaction failed |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |
| busy_o | output | 1 | A dump is in progress |
| byte_valid_o | output | 1 | One-cycle strobe for `byte_o` |
| byte_o | output | 8 | Fuse byte |
| done_o | output | 1 | One-cycle end-of-dump pulse |
| error_o | output | 1 | Set with `done_o` when the dump was aborted |

## Verification
Two events can fall in the same cycle: delivery of the final byte and the completion pulse. A single-byte dump and a multi-byte dump that crosses the 0x0FF/0x100 address boundary provoke this. The bench then requires `byte_valid_o` to be high in the cycle where `done_o` is first seen. The second case is a poll acknowledge that reports both an error and a set ready bit. The slave model returns exactly that on the first poll of each byte. The bench judges the block by whether it waits the gap and polls again, rather than fetching the byte.

// File: rtl/fsd_pkg.sv
`timescale 1ns/1ps
package fsd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_POLL,
        ST_GAP,
        ST_FETCH
    } fsd_state_e;

    localparam logic [7:0] ARM_VALUE  = 8'h40;
    localparam logic [7:0] MASK_FULL  = 8'hFF;
    localparam logic [7:0] MASK_HIGH  = 8'h0F;
    localparam logic [7:0] MASK_MODE  = 8'hC0;
    localparam int         READY_BIT  = 5;
endpackage

// File: rtl/fsd_setup_gen.sv
`timescale 1ns/1ps
module fsd_setup_gen #(
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] CTRL_REG = 8'h60,
    parameter logic [7:0] LOW_REG  = 8'h61
) (
    input  logic [1:0]        step_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        reg_o,
    output logic [7:0]        wdata_o,
    output logic [7:0]        wmask_o
);
    import fsd_pkg::*;

    logic [ADDR_W-1:0] upper;
    assign upper = addr_i >> 8;

    always_comb begin
        unique case (step_i)
            2'd0: begin
                reg_o   = CTRL_REG;
                wdata_o = ARM_VALUE;
                wmask_o = MASK_FULL;
            end
            2'd1: begin
                reg_o   = LOW_REG;
                wdata_o = addr_i[7:0];
                wmask_o = MASK_FULL;
            end
            2'd2: begin
                reg_o   = CTRL_REG;
                wdata_o = upper[7:0];
                wmask_o = MASK_HIGH;
            end
            default: begin
                reg_o   = CTRL_REG;
                wdata_o = 8'h00;
                wmask_o = MASK_MODE;
            end
        endcase
    end
endmodule

// File: rtl/fsd_poll_timer.sv
`timescale 1ns/1ps
module fsd_poll_timer #(
    parameter int POLL_GAP   = 200,
    parameter int POLL_LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic new_byte_i,
    input  logic poll_done_i,
    input  logic gap_load_i,
    input  logic gap_run_i,
    output logic gap_zero_o,
    output logic last_try_o
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int TW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [TW-1:0] tries;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (new_byte_i)
            tmr_d.tries = '0;
        else if (poll_done_i)
            tmr_d.tries = tmr_q.tries + TW'(1);
        if (gap_load_i)
            tmr_d.gap = GW'(POLL_GAP - 1);
        else if (gap_run_i && tmr_q.gap != '0)
            tmr_d.gap = tmr_q.gap - GW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign gap_zero_o = (tmr_q.gap == '0);
    assign last_try_o = (tmr_q.tries == TW'(POLL_LIMIT - 1));

    // R4
    budget_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done_i |-> (tmr_q.tries < TW'(POLL_LIMIT)));
endmodule

// File: rtl/fsd_addr_walker.sv
`timescale 1ns/1ps
module fsd_addr_walker #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
    } walk_s;

    walk_s walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        if (load_i) begin
            walk_d.addr = base_i;
            walk_d.left = len_i;
        end else if (step_i) begin
            walk_d.addr = walk_q.addr + ADDR_W'(1);
            walk_d.left = walk_q.left - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign addr_o = walk_q.addr;
    assign last_o = (walk_q.left == LEN_W'(1));

    // R5
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (walk_q.left > LEN_W'(1)));
endmodule

// File: rtl/fuse_si_reader.sv
`timescale 1ns/1ps
module fuse_si_reader #(
    parameter int         ADDR_W     = 12,
    parameter int         LEN_W      = 12,
    parameter int         POLL_GAP   = 200,
    parameter int         POLL_LIMIT = 10000,
    parameter logic [7:0] CTRL_REG   = 8'h60,
    parameter logic [7:0] LOW_REG    = 8'h61,
    parameter logic [7:0] RDVAL_REG  = 8'h62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [7:0]        bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    output logic [7:0]        bus_wmask_o,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic [7:0]        bus_rdata_i,
    output logic              busy_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o,
    output logic              done_o,
    output logic              error_o
);
    import fsd_pkg::*;

    typedef struct packed {
        fsd_state_e state;
        logic [1:0] step;
        logic       bv;
        logic [7:0] bdata;
        logic       done;
        logic       err;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [ADDR_W-1:0] cur_addr;
    logic              last_byte;
    logic [7:0]        setup_reg, setup_data, setup_mask;
    logic              gap_zero, last_try;
    logic              acked, poll_ok;
    logic              walk_load, walk_step, poll_done, gap_load;

    assign acked     = bus_req_o && bus_ack_i;
    assign poll_ok   = !bus_err_i && bus_rdata_i[READY_BIT];
    assign walk_load = (seq_q.state == ST_IDLE) && start_i && (len_i != '0);
    assign walk_step = (seq_q.state == ST_FETCH) && acked && !bus_err_i && !last_byte;
    assign poll_done = (seq_q.state == ST_POLL) && acked;
    assign gap_load  = poll_done && !poll_ok && !last_try;

    fsd_setup_gen #(
        .ADDR_W   (ADDR_W),
        .CTRL_REG (CTRL_REG),
        .LOW_REG  (LOW_REG)
    ) u_setup (
        .step_i  (seq_q.step),
        .addr_i  (cur_addr),
        .reg_o   (setup_reg),
        .wdata_o (setup_data),
        .wmask_o (setup_mask)
    );

    fsd_addr_walker #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (walk_load),
        .base_i (base_i),
        .len_i  (len_i),
        .step_i (walk_step),
        .addr_o (cur_addr),
        .last_o (last_byte)
    );

    fsd_poll_timer #(
        .POLL_GAP   (POLL_GAP),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .new_byte_i  (walk_load || walk_step),
        .poll_done_i (poll_done),
        .gap_load_i  (gap_load),
        .gap_run_i   (seq_q.state == ST_GAP),
        .gap_zero_o  (gap_zero),
        .last_try_o  (last_try)
    );

    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = 8'h00;
        bus_wdata_o = 8'h00;
        bus_wmask_o = 8'h00;
        unique case (seq_q.state)
            ST_SETUP: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = setup_reg;
                bus_wdata_o = setup_data;
                bus_wmask_o = setup_mask;
            end
            ST_POLL: begin
                bus_req_o  = 1'b1;
                bus_addr_o = CTRL_REG;
            end
            ST_FETCH: begin
                bus_req_o  = 1'b1;
                bus_addr_o = RDVAL_REG;
            end
            default: ;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.bv   = 1'b0;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (len_i == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.state = ST_SETUP;
                        seq_d.step  = 2'd0;
                    end
                end
            end
            ST_SETUP: begin
                if (acked) begin
                    if (bus_err_i) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.err   = 1'b1;
                    end else if (seq_q.step == 2'd3) begin
                        seq_d.state = ST_POLL;
                    end else begin
                        seq_d.step = seq_q.step + 2'd1;
                    end
                end
            end
            ST_POLL: begin
                if (acked) begin
                    if (poll_ok) begin
                        seq_d.state = ST_FETCH;
                    end else if (last_try) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.err   = 1'b1;
                    end else begin
                        seq_d.state = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (gap_zero) seq_d.state = ST_POLL;
            end
            ST_FETCH: begin
                if (acked) begin
                    if (bus_err_i) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.err   = 1'b1;
                    end else begin
                        seq_d.bv    = 1'b1;
                        seq_d.bdata = bus_rdata_i;
                        if (last_byte) begin
                            seq_d.state = ST_IDLE;
                            seq_d.done  = 1'b1;
                        end else begin
                            seq_d.state = ST_SETUP;
                            seq_d.step  = 2'd0;
                        end
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o       = (seq_q.state != ST_IDLE);
    assign byte_valid_o = seq_q.bv;
    assign byte_o       = seq_q.bdata;
    assign done_o       = seq_q.done;
    assign error_o      = seq_q.err;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o)
                                       && $stable(bus_wdata_o) && $stable(bus_wmask_o)));

    // R3
    poll_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_ack_i && !bus_we_o && bus_addr_o == CTRL_REG
         && (bus_err_i || !bus_rdata_i[READY_BIT])) |=> !bus_req_o);

    // R5
    byte_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(bus_req_o && bus_ack_i && !bus_err_i && !bus_we_o
                               && bus_addr_o == RDVAL_REG));

    // R7
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !bus_req_o));
endmodule

// File: tb/fuse_si_reader_test.sv
`timescale 1ns/1ps
module fuse_si_reader_test;
    localparam int         AW    = 12;
    localparam int         LW    = 12;
    localparam int         GAP   = 3;
    localparam int         LIM   = 5;
    localparam logic [7:0] CTRL  = 8'h60;
    localparam logic [7:0] LOWR  = 8'h61;
    localparam logic [7:0] RDV   = 8'h62;

    typedef struct packed {
        logic       we;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] m;
    } txn_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] base = '0;
    logic [LW-1:0] len = '0;
    logic req, we, ack, err, busy, bv, done, error;
    logic [7:0] addr, wdata, wmask, rdata, bout;

    always #2.5 clk = ~clk;

    fuse_si_reader #(
        .ADDR_W(AW), .LEN_W(LW), .POLL_GAP(GAP), .POLL_LIMIT(LIM),
        .CTRL_REG(CTRL), .LOW_REG(LOWR), .RDVAL_REG(RDV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .len_i(len),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
        .bus_wmask_o(wmask), .bus_ack_i(ack), .bus_err_i(err), .bus_rdata_i(rdata),
        .busy_o(busy), .byte_valid_o(bv), .byte_o(bout), .done_o(done), .error_o(error)
    );

    function automatic logic [7:0] fz(int a);
        return 8'((a * 37 + 11) ^ (a >> 4));
    endfunction

    // scenario configuration, written only by the stimulus process
    int   cfg_nr = 0;
    int   cfg_pe = 0;
    int   cfg_err_at = -1;
    txn_t exp_t [64];
    int   exp_n = 0;
    logic [7:0] exp_b [64];
    int   exp_nb = 0;

    // register-bus slave model
    logic [7:0] s_ctrl = 8'h00;
    logic [7:0] s_low = 8'h00;
    int s_idx = 0;
    int s_poll = 0;
    int s_wait = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; err <= 1'b0; rdata <= 8'h00;
            s_idx = 0; s_poll = 0; s_wait = 0;
        end else if (start && !busy) begin
            ack <= 1'b0; s_idx = 0; s_poll = 0; s_wait = 0;
        end else if (ack) begin
            ack <= 1'b0; err <= 1'b0; s_wait = 0;
        end else if (req) begin
            if (s_wait < (s_idx % 3)) begin
                s_wait++;
            end else begin
                logic e;
                logic [7:0] r;
                e = (s_idx == cfg_err_at);
                r = 8'h00;
                s_wait = 0;
                if (we) begin
                    if (addr == CTRL) begin
                        s_ctrl = (s_ctrl & ~wmask) | (wdata & wmask);
                        if (wmask == 8'hC0 && (wdata & 8'hC0) == 8'h00) s_poll = 0;
                    end else if (addr == LOWR) begin
                        s_low = (s_low & ~wmask) | (wdata & wmask);
                    end
                end else if (addr == CTRL) begin
                    logic pe_now;
                    pe_now = (cfg_pe != 0) && (s_poll == 0);
                    r = s_ctrl | (((s_poll >= cfg_nr + cfg_pe) || pe_now) ? 8'h20 : 8'h00);
                    e = e | pe_now;
                    s_poll++;
                end else if (addr == RDV) begin
                    r = fz({20'd0, s_ctrl[3:0], s_low});
                end
                ack <= 1'b1; err <= e; rdata <= r;
                s_idx++;
            end
        end
    end

    // reference comparison, every clock at the falling edge
    int m_chk = 0, m_fail = 0, m_n = 0, m_b = 0, g_cnt = 0;
    bit g_on = 0;
    always @(negedge clk) begin
        if (start && !busy) begin
            m_n = 0; m_b = 0; g_on = 0; g_cnt = 0;
        end else if (rst_n) begin
            if (g_on) begin
                if (req) begin
                    m_chk++;
                    if (g_cnt != GAP) begin
                        m_fail++;
                        $display("FAIL R3 idle cycles between polls: actual %0d expected %0d", g_cnt, GAP);
                    end
                    g_on = 0;
                end else begin
                    g_cnt++;
                end
            end
            if (req && ack) begin
                m_chk++;
                if (m_n >= exp_n) begin
                    m_fail++;
                    $display("FAIL R2 extra bus transaction %0d: actual addr %h expected none (%0d total)", m_n, addr, exp_n);
                end else if (we != exp_t[m_n].we || addr != exp_t[m_n].a ||
                             (we && (wdata != exp_t[m_n].d || wmask != exp_t[m_n].m))) begin
                    m_fail++;
                    $display("FAIL R2 transaction %0d: actual we%0d a%h d%h m%h expected we%0d a%h d%h m%h",
                             m_n, we, addr, wdata, wmask, exp_t[m_n].we, exp_t[m_n].a,
                             exp_t[m_n].d, exp_t[m_n].m);
                end
                if (!we && addr == CTRL && (err || !rdata[5])) begin
                    g_on = 1; g_cnt = 0;
                end
                m_n++;
            end
            if (bv) begin
                m_chk++;
                if (m_b >= exp_nb || bout != exp_b[m_b]) begin
                    m_fail++;
                    $display("FAIL R5 byte %0d: actual %h expected %h", m_b, bout,
                             (m_b < exp_nb) ? exp_b[m_b] : 8'hxx);
                end
                m_b++;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    task automatic check(bit ok, string rq, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic push(logic w, logic [7:0] a, logic [7:0] d, logic [7:0] m);
        if (exp_n < 64) begin
            exp_t[exp_n] = '{we: w, a: a, d: d, m: m};
            exp_n++;
        end
    endtask

    task automatic build(int b, int n, int nr, int pe);
        exp_n = 0; exp_nb = 0;
        for (int i = 0; i < n; i++) begin
            int a;
            int need;
            a = b + i;
            push(1'b1, CTRL, 8'h40, 8'hFF);
            push(1'b1, LOWR, 8'(a), 8'hFF);
            push(1'b1, CTRL, 8'(a >> 8), 8'h0F);
            push(1'b1, CTRL, 8'h00, 8'hC0);
            need = nr + pe + 1;
            if (need > LIM) begin
                for (int k = 0; k < LIM; k++) push(1'b0, CTRL, 8'h00, 8'h00);
                return;
            end
            for (int k = 0; k < need; k++) push(1'b0, CTRL, 8'h00, 8'h00);
            push(1'b0, RDV, 8'h00, 8'h00);
            if (exp_nb < 64) begin
                exp_b[exp_nb] = fz(a);
                exp_nb++;
            end
        end
    endtask

    task automatic run(string rq, int b, int n, int nr, int pe, int erat,
                       bit xerr, int xt, int xb, bit poke);
        int cyc;
        cfg_nr = nr; cfg_pe = pe; cfg_err_at = erat;
        build(b, n, nr, pe);
        @(posedge clk); #1;
        start = 1'b1; base = AW'(b); len = LW'(n);
        @(posedge clk); #1;
        start = 1'b0;
        if (n == 0) check(done == 1'b1, "R9", "done one cycle after zero-length start", done, 1);
        if (poke) begin
            repeat (3) @(posedge clk);
            #1;
            check(busy == 1'b1, "R10", "busy before second start", busy, 1);
            start = 1'b1; base = AW'(12'h200); len = LW'(5);
            @(posedge clk); #1;
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, rq, "dump reached done", done, 1);
        check(error == xerr, (xerr ? "R7" : rq), "error flag with done", error, xerr);
        if (!xerr && xb > 0) check(bv == 1'b1, "R8", "last byte strobe with done", bv, 1);
        repeat (8) @(negedge clk);
        check(m_n == xt, (xerr ? "R7" : "R2"), "bus transactions in dump", m_n, xt);
        check(m_b == xb, (poke ? "R10" : "R5"), "bytes delivered", m_b, xb);
        check(req == 1'b0 && busy == 1'b0, rq, "quiet after done", req, 0);
    endtask

    initial begin
        #(150000 * 5);
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + m_chk + 1, n_fail + m_fail + 1);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && req == 0 && bv == 0 && done == 0 && error == 0, "R1",
              "idle outputs after reset", {busy, req, bv, done, error}, 0);
        // R2 R5 R8: plain dump crossing the 0x0FF/0x100 boundary
        run("R2", 12'h0FE, 4, 0, 0, -1, 1'b0, 24, 4, 1'b0);
        // R3: two not-ready polls per byte
        run("R3", 12'h345, 2, 2, 0, -1, 1'b0, 16, 2, 1'b0);
        // R3: first poll has error and ready bit both set, must be retried
        run("R3", 12'h0A0, 2, 0, 1, -1, 1'b0, 14, 2, 1'b0);
        // R4: ready never comes
        run("R4", 12'h010, 2, 100, 0, -1, 1'b1, 4 + LIM, 0, 1'b0);
        // R7: error on the third setup write
        run("R7", 12'h020, 3, 0, 0, 2, 1'b1, 3, 0, 1'b0);
        // R7: error on the second data read
        run("R7", 12'h030, 3, 0, 0, 11, 1'b1, 12, 1, 1'b0);
        // R9: zero length
        run("R9", 12'h040, 0, 0, 0, -1, 1'b0, 0, 0, 1'b0);
        // R10 R8: start pulsed while busy
        run("R10", 12'h7F0, 1, 0, 0, -1, 1'b0, 6, 1, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + m_chk, n_fail + m_fail);
        $finish;
    end
endmodule